// File: doc/BRIEF.md
# Grouped Prescaler and Divider Tick Generator

This block derives one count-enable strobe per timer channel from a single input clock. Two free-running 8-bit prescalers each serve a group of channels: the first group is the low channels, the second the remaining ones. Behind its group's prescaler, each channel has a binary divider chosen by a 4-bit log2 code. A tick for a channel is a one-cycle pulse that occurs once every (prescale × divider) input clocks. The downstream counters use it as their count enable.

Both configuration words are loaded through one plain write port. A write does not disturb a running period. The new values wait until the affected prescaler next wraps. At that wrap they are loaded together, and the prescaler and divider counters restart from zero. A parameter selects the divider code base, so the same RTL covers a variant where code 0 means /2 and one where code 0 means /1.

Top module: `tmr_tick_gen`

## Requirements
- R1: A synchronous reset holds every tick low, clears both configuration words and restarts all counters. The first clock edge after release already acts on the cleared fields, so with DIV_BASE=0 every channel ticks in every cycle from the first cycle after that edge. With DIV_BASE=1, ticks appear in every second cycle, starting one cycle later.
- R2: cfg_sel=0 writes the prescale word. Bits 7:0 serve channels 0 and 1, and bits 15:8 serve channels 2 to 4. A stored value N divides by N+1.
- R3: cfg_sel=1 writes the divider word. Channel c takes its code from bits 4c+3:4c, and the divider is 2^(code+DIV_BASE).
- R4: A channel ticks every P×D cycles, where P is its group's prescale ratio and D is its divider. Each tick lasts one cycle.
- R5: If code+DIV_BASE exceeds MAX_LOG2 (default 4), the divider saturates at 2^MAX_LOG2 (16).
- R6: A write sets an update pending on both groups. Each group applies it at its first prescaler wrap in a cycle no earlier than the cycle after the write edge. Suppose that wrap falls in cycle c. Then no tick appears in cycle c+1, and the group's channels tick in cycles c+1+m·P·D for m ≥ 1, using the new values.
- R7: The tick is registered. It appears in the cycle after the prescaler wrap that completes the channel's divider count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_sel | input | 1 | 0 selects the prescale word, 1 selects the divider word |
| cfg_wdata | input | CFG_W (32) | Write data |
| tick | output | NUM_CH (5) | One-cycle count-enable strobe for each channel |

## Verification
Every internal counter shows at the ports through the timing of the ticks. A prescaler that stalls or runs with the wrong ratio stretches or shrinks every tick period of its group. A divider count that is off, or a saturation that is wrong, moves the channel's first tick after a configuration write. A deferred update that is applied too early or too late shifts the phase of the whole tick train. In each of these cases the first tick after the update already lands in a cycle other than the one the requirements predict. The bench predicts every tick cycle across a horizon for both divider-base variants, so such a fault is visible at the first wrong tick.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

   // Selects the configuration word addressed by a write.
   typedef enum logic {
      CFG_PRESCALE = 1'b0,
      CFG_DIVSEL   = 1'b1
   } cfg_sel_e;

   // Effective log2 of a divider: code plus base, saturated at the maximum.
   function automatic int unsigned tick_log2(input int unsigned code,
                                             input int unsigned base,
                                             input int unsigned max_log2);
      int unsigned s;
      s = code + base;
      return (s > max_log2) ? max_log2 : s;
   endfunction

endpackage

// File: rtl/tmr_tick_cfg.sv
module tmr_tick_cfg
   import tmr_tick_pkg::*;
#(
   parameter int unsigned NUM_CH  = 5,
   parameter int unsigned NUM_GRP = 2,
   parameter int unsigned PRE_W   = 8,
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned CFG_W   = 32
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic                      cfg_sel,
   input  logic [CFG_W-1:0]          cfg_wdata,
   input  logic [NUM_GRP-1:0]        grp_wrap,
   output logic [NUM_GRP*PRE_W-1:0]  pre_stage,
   output logic [NUM_CH*SEL_W-1:0]   sel_stage,
   output logic [NUM_GRP-1:0]        pend
);

   localparam int unsigned PRE_BITS = NUM_GRP * PRE_W;
   localparam int unsigned SEL_BITS = NUM_CH * SEL_W;

   logic [PRE_BITS-1:0] pre_q;
   logic [SEL_BITS-1:0] sel_q;
   logic [NUM_GRP-1:0]  pend_q;
   logic                unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q <= '0;
         sel_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_DIVSEL) sel_q <= cfg_wdata[SEL_BITS-1:0];
         else                       pre_q <= cfg_wdata[PRE_BITS-1:0];
      end
   end

   // A new write wins over a wrap in the same cycle: the update stays pending.
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_pend
      always_ff @(posedge clk) begin
         if (rst) pend_q[g] <= 1'b0;
         else     pend_q[g] <= cfg_we | (pend_q[g] & ~grp_wrap[g]);
      end

      // R6
      pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
         (pend_q[g] && grp_wrap[g] && !cfg_we) |=> !pend_q[g]);
   end

   assign pre_stage = pre_q;
   assign sel_stage = sel_q;
   assign pend      = pend_q;

   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> (pend_q == {NUM_GRP{1'b1}}));

endmodule

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PRE_W-1:0] stage_i,
   input  logic             pend_i,
   output logic             wrap_o,
   output logic             apply_o
);

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] act_q;

   assign wrap_o  = (cnt_q == act_q);
   assign apply_o = wrap_o & pend_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (wrap_o) begin
         cnt_q <= '0;
         if (pend_i) act_q <= stage_i;
      end else begin
         cnt_q <= cnt_q + PRE_W'(1);
      end
   end

   // R2
   pre_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= act_q);

   // R2
   pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
      wrap_o |=> (cnt_q == '0));

   // R6
   pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wrap_o |=> $stable(act_q));

endmodule

// File: rtl/tmr_tick_divider.sv
module tmr_tick_divider
   import tmr_tick_pkg::*;
#(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned DIV_BASE = 0,
   parameter int unsigned MAX_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap_i,
   input  logic             apply_i,
   input  logic [SEL_W-1:0] code_i,
   output logic             tick_o
);

   localparam int unsigned CNT_W = MAX_LOG2;
   localparam int unsigned LOG_W = $clog2(MAX_LOG2 + 1);
   localparam logic [LOG_W-1:0] RST_LOG2 = LOG_W'(tick_log2(0, DIV_BASE, MAX_LOG2));

   logic [CNT_W-1:0] dcnt_q;
   logic [LOG_W-1:0] log2_q;
   logic [LOG_W-1:0] log2_new;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] lim;
   logic             last;
   logic             tick_q;

   assign log2_new = LOG_W'(tick_log2(32'(code_i), DIV_BASE, MAX_LOG2));
   assign span     = (CNT_W + 1)'(1) << log2_q;
   assign lim      = CNT_W'(span - (CNT_W + 1)'(1));
   assign last     = (dcnt_q == lim);

   always_ff @(posedge clk) begin
      if (rst) begin
         dcnt_q <= '0;
         log2_q <= RST_LOG2;
         tick_q <= 1'b0;
      end else begin
         tick_q <= wrap_i & ~apply_i & last;
         if (apply_i) begin
            dcnt_q <= '0;
            log2_q <= log2_new;
         end else if (wrap_i) begin
            dcnt_q <= last ? '0 : dcnt_q + CNT_W'(1);
         end
      end
   end

   assign tick_o = tick_q;

   // R7
   tick_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      tick_q |-> $past(wrap_i));

   // R6
   no_tick_on_apply_chk: assert property (@(posedge clk) disable iff (rst)
      apply_i |=> !tick_q);

   // R5
   log2_range_chk: assert property (@(posedge clk) disable iff (rst)
      log2_q <= LOG_W'(MAX_LOG2));

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_tick_pkg::*;
#(
   parameter int unsigned NUM_CH    = 5,
   parameter int unsigned GRP_SPLIT = 2,
   parameter int unsigned PRE_W     = 8,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned CFG_W     = 32,
   parameter int unsigned DIV_BASE  = 0,
   parameter int unsigned MAX_LOG2  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [NUM_CH-1:0] tick
);

   localparam int unsigned NUM_GRP = 2;

   if (NUM_GRP * PRE_W > CFG_W) begin : g_bad_pre
      $error("prescale fields do not fit the write word");
   end
   if (NUM_CH * SEL_W > CFG_W) begin : g_bad_sel
      $error("divider fields do not fit the write word");
   end
   if (GRP_SPLIT < 1 || GRP_SPLIT >= NUM_CH) begin : g_bad_split
      $error("group split must leave channels in both groups");
   end
   if (MAX_LOG2 < 1 || DIV_BASE > MAX_LOG2) begin : g_bad_div
      $error("divider range parameters inconsistent");
   end

   logic [NUM_GRP*PRE_W-1:0] pre_stage;
   logic [NUM_CH*SEL_W-1:0]  sel_stage;
   logic [NUM_GRP-1:0]       pend;
   logic [NUM_GRP-1:0]       grp_wrap;
   logic [NUM_GRP-1:0]       grp_apply;

   tmr_tick_cfg #(
      .NUM_CH (NUM_CH),
      .NUM_GRP(NUM_GRP),
      .PRE_W  (PRE_W),
      .SEL_W  (SEL_W),
      .CFG_W  (CFG_W)
   ) i_cfg (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .grp_wrap (grp_wrap),
      .pre_stage(pre_stage),
      .sel_stage(sel_stage),
      .pend     (pend)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      tmr_tick_prescaler #(.PRE_W(PRE_W)) i_pre (
         .clk    (clk),
         .rst    (rst),
         .stage_i(pre_stage[g*PRE_W +: PRE_W]),
         .pend_i (pend[g]),
         .wrap_o (grp_wrap[g]),
         .apply_o(grp_apply[g])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned GRP = (c < GRP_SPLIT) ? 0 : 1;

      tmr_tick_divider #(
         .SEL_W   (SEL_W),
         .DIV_BASE(DIV_BASE),
         .MAX_LOG2(MAX_LOG2)
      ) i_div (
         .clk    (clk),
         .rst    (rst),
         .wrap_i (grp_wrap[GRP]),
         .apply_i(grp_apply[GRP]),
         .code_i (sel_stage[c*SEL_W +: SEL_W]),
         .tick_o (tick[c])
      );

      // R4
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
         (tick[c] && !$past(grp_wrap[GRP])) |-> 1'b0);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (tick == '0));

endmodule

// File: tb/test_tmr_tick_gen.sv
`timescale 1ns/1ps
module test_tmr_tick_gen;

   localparam int NCH   = 5;
   localparam int SPLIT = 2;
   localparam int MAXL  = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           cfg_we = 1'b0;
   logic           cfg_sel = 1'b0;
   logic [31:0]    cfg_wdata = '0;
   logic [NCH-1:0] tick_a;
   logic [NCH-1:0] tick_b;

   always #2.5 clk = ~clk;

   tmr_tick_gen #(.DIV_BASE(0)) i_tmr_tick_gen (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tick(tick_a));

   tmr_tick_gen #(.DIV_BASE(1)) i_tmr_tick_gen_b (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tick(tick_b));

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   int    exp_q [2][NCH][$];
   bit    mon_on = 1'b0;
   int    mon_from = 0;
   string cur_req = "R4";
   int    cur_pre [2];
   int    cur_code [NCH];
   int    app_c [2];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   function automatic int div_of(input int code, input int base);
      int s;
      s = code + base;
      if (s > MAXL) s = MAXL;
      return 1 << s;
   endfunction

   function automatic int grp_of(input int c);
      return (c < SPLIT) ? 0 : 1;
   endfunction

   // Monitor: pops the scoreboard as ticks arrive.
   always @(negedge clk) begin
      if (mon_on && cyc >= mon_from) begin
         for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < NCH; c++) begin
               bit t;
               bit e;
               t = (i == 0) ? tick_a[c] : tick_b[c];
               e = (exp_q[i][c].size() > 0) && (exp_q[i][c][0] == cyc);
               if (e) begin
                  void'(exp_q[i][c].pop_front());
                  chk(t, cur_req, int'(t), 1);
               end else if (t) begin
                  chk(1'b0, cur_req, 1, 0);
               end
            end
         end
      end
   end

   task automatic wr(input logic sel, input logic [31:0] d, output int w);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      w = cyc;
      cfg_we = 1'b0;
   endtask

   task automatic drain(input int end_c);
      while (cyc < end_c + 1) @(negedge clk);
      mon_on = 1'b0;
      for (int i = 0; i < 2; i++)
         for (int c = 0; c < NCH; c++)
            chk(exp_q[i][c].size() == 0, cur_req, exp_q[i][c].size(), 0);
      for (int i = 0; i < 2; i++)
         for (int c = 0; c < NCH; c++)
            exp_q[i][c].delete();
   endtask

   // R1: ticks low in reset; fields cleared afterwards.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(tick_a == '0 && tick_b == '0, "R1", int'({tick_b, tick_a}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(tick_a == '1, "R1", int'(tick_a), 31);
      chk(tick_b == '0, "R1", int'(tick_b), 0);
      @(negedge clk);
      chk(tick_a == '1, "R1", int'(tick_a), 31);
      chk(tick_b == '1, "R1", int'(tick_b), 31);
   endtask

   // Fresh programming from cleared fields: divider word, then prescale word.
   task automatic run_fresh(input logic [31:0] pre_w, input logic [31:0] div_w,
                            input int span, input string req);
      int w;
      int end_c;
      cur_req = req;
      wr(1'b1, div_w, w);
      wr(1'b0, pre_w, w);
      for (int g = 0; g < 2; g++) begin
         cur_pre[g] = int'(pre_w[g*8 +: 8]);
         app_c[g]   = w;
      end
      for (int c = 0; c < NCH; c++) cur_code[c] = int'(div_w[c*4 +: 4]);
      end_c = w + 1 + span;
      for (int i = 0; i < 2; i++) begin
         for (int c = 0; c < NCH; c++) begin
            int pd;
            pd = (cur_pre[grp_of(c)] + 1) * div_of(cur_code[c], i);
            for (int t = w + 1 + pd; t <= end_c; t += pd) exp_q[i][c].push_back(t);
         end
      end
      mon_from = w + 1;
      mon_on   = 1'b1;
      drain(end_c);
   endtask

   // R6: prescale rewrite while running; each group applies at its next wrap.
   task automatic run_update(input logic [31:0] pre_w, input int span);
      int w;
      int cn [2];
      int start;
      int end_c;
      cur_req = "R6";
      wr(1'b0, pre_w, w);
      for (int g = 0; g < 2; g++) begin
         int c;
         c = app_c[g] + 1 + cur_pre[g];
         while (c < w) c += cur_pre[g] + 1;
         cn[g]      = c;
         app_c[g]   = c;
         cur_pre[g] = int'(pre_w[g*8 +: 8]);
      end
      start = ((cn[0] > cn[1]) ? cn[0] : cn[1]) + 1;
      end_c = start + span;
      for (int i = 0; i < 2; i++) begin
         for (int c = 0; c < NCH; c++) begin
            int pd;
            int g;
            g  = grp_of(c);
            pd = (cur_pre[g] + 1) * div_of(cur_code[c], i);
            for (int t = cn[g] + 1 + pd; t <= end_c; t += pd)
               if (t >= start) exp_q[i][c].push_back(t);
         end
      end
      mon_from = start;
      mon_on   = 1'b1;
      drain(end_c);
   endtask

   initial begin
      #(20000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R2 R3 R4 R5: pre1=2, pre0=0; codes 0,1,2,7(saturates),0
      run_fresh(32'h0000_0200, 32'h0000_7210, 150, "R2/R3/R4/R5");
      do_reset();
      // R2 R3 R5 R7: pre0=4, pre1=0; codes 3,0,1,15,5
      run_fresh(32'h0000_0004, 32'h0005_F103, 200, "R3/R5/R7");
      // R6: pre0=1, pre1=3 while running
      run_update(32'h0000_0301, 200);
      // R1: reset after non-zero configuration
      do_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule